// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is a single pulse-width-modulated output channel. A prescaler divides the main clock by a power of two, and a period counter steps once per prescaled tick. Each period opens at the inactive output level. The output turns active once the count reaches the programmed inactive length (`duty`). The active time is therefore the period length minus `duty`. A polarity input picks whether "active" means a high or a low output.

Live period and duty values can be loaded directly only while the channel is stopped. While it runs, new values go through one shared update port that holds a single value. A select bit tells the port whether the value is for duty or period. The held value is copied into the live register only at the end of the current period, so a waveform never changes shape in the middle of a period. A one-cycle `period_start` pulse marks the first cycle of every new period. That pulse tells a controller that any held update is now live.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: One count lasts 2^s clock cycles, where s is `pres_sel` for values 0 to 10. Any `pres_sel` above 10 behaves as 10.
- R2: For a live period P≥1, a period lasts P counts, that is P·2^s clocks. `period_start` is high for exactly one clock, in the first cycle of each period that follows a completed period.
- R3: Within a period, the output is at its inactive level for the first `duty` counts and at its active level for the rest. The active level is high when `pol_inv`=0 and low when `pol_inv`=1.
- R4: With `duty`=0 the whole period is active. With `duty`≥P the whole period is inactive.
- R5: While the channel is enabled, an `upd_wr` value is held. It becomes live only at the end of the period in progress, and it is live in the cycle where `period_start` is high.
- R6: `upd_sel`=0 sends the update to duty. `upd_sel`=1 sends it to period.
- R7: An update written in the last clock of a period does not catch that boundary. It becomes live one period later.
- R8: While the channel is disabled, `dir_wr` loads both live values at once, and `upd_wr` loads the selected live value at once.
- R9: While the channel is enabled, `dir_wr` is ignored.
- R10: While the channel is disabled, the counters are cleared, the output sits at the inactive level (equal to `pol_inv`), `period_start` stays low, and any held update is discarded.
- R11: After reset, the live values are zero, no update is held, `period_start` is low and the output is at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel run enable |
| pres_sel | input | 4 | Prescale exponent (0..10; larger values are treated as 10) |
| pol_inv | input | 1 | 0: active level high, 1: active level low |
| dir_wr | input | 1 | Direct load of both live values (only while disabled) |
| dir_period | input | W | Direct period value |
| dir_duty | input | W | Direct inactive-length value |
| upd_wr | input | 1 | Write to the shared update port |
| upd_sel | input | 1 | Update target: 0 duty, 1 period |
| upd_val | input | W | Update value |
| pwm_out | output | 1 | Waveform output |
| period_start | output | 1 | One-cycle pulse in the first cycle of a new period |

## Verification
The same-cycle case that matters is an update write that lands on the clock in which the period wraps. Here the buffer capture and the boundary copy fall on one edge. The bench provokes it by driving `upd_wr` in the last sampled cycle of a measured period. It then checks, count by count, that the next period still has the old shape and the period after that has the new one. Random periods, duties, prescales and polarities, with updates at random points inside a period, also exercise the ordinary capture-then-apply path.

// File: rtl/pwm_chan_pkg.sv
// Shared constants and types for the PWM channel.
package pwm_chan_pkg;
    localparam int PRES_W   = 4;   // width of the prescale select
    localparam int MAX_PRES = 10;  // largest legal prescale exponent

    typedef enum logic {
        UPD_DUTY   = 1'b0,
        UPD_PERIOD = 1'b1
    } upd_tgt_e;
endpackage

// File: rtl/pwm_tick_gen.sv
// Prescale tick generator: pulses tick once every 2^s clocks while enabled,
// with s the clamped prescale select. Assumes pres_sel is static while running.
module pwm_tick_gen
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [PRES_W-1:0] pres_sel,
    output logic              tick
);
    logic [MAX_PRES-1:0] div_q;
    logic [PRES_W-1:0]   pres_eff;
    logic [MAX_PRES-1:0] mask;

    // Clamp the exponent and build the low-bit mask.
    always_comb begin
        pres_eff = (pres_sel > PRES_W'(MAX_PRES)) ? PRES_W'(MAX_PRES) : pres_sel;
        mask     = MAX_PRES'((32'd1 << pres_eff) - 32'd1);
        tick     = chan_en && ((div_q & mask) == mask);
    end

    // Free-running divider, cleared while the channel is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !tick || pres_eff == '0) else $error("divider not cleared"); // R10
endmodule

// File: rtl/pwm_live_regs.sv
// Live period/duty registers with a single-entry update buffer.
// Stopped: direct loads take effect at once. Running: updates are held and
// copied at the period boundary; a write in the boundary cycle waits a period.
module pwm_live_regs
    import pwm_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         boundary,
    input  logic         dir_wr,
    input  logic [W-1:0] dir_period,
    input  logic [W-1:0] dir_duty,
    input  logic         upd_wr,
    input  logic         upd_sel,
    input  logic [W-1:0] upd_val,
    output logic [W-1:0] period_q,
    output logic [W-1:0] duty_q
);
    logic         pend_q;
    upd_tgt_e     tgt_q;
    logic [W-1:0] val_q;

    // Load, buffer and apply the live values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
            pend_q   <= 1'b0;
            tgt_q    <= UPD_DUTY;
            val_q    <= '0;
        end else if (!chan_en) begin
            pend_q <= 1'b0;
            if (dir_wr) begin
                period_q <= dir_period;
                duty_q   <= dir_duty;
            end
            if (upd_wr) begin
                if (upd_sel) period_q <= upd_val;
                else         duty_q   <= upd_val;
            end
        end else begin
            if (boundary && pend_q) begin
                if (tgt_q == UPD_PERIOD) period_q <= val_q;
                else                     duty_q   <= val_q;
            end
            if (upd_wr) begin
                pend_q <= 1'b1;
                tgt_q  <= upd_tgt_e'(upd_sel);
                val_q  <= upd_val;
            end else if (boundary) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && !boundary |=> $stable(period_q) && $stable(duty_q))
        else $error("live value changed mid-period"); // R5
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && boundary && !upd_wr |=> !pend_q) else $error("pending kept"); // R5
    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !pend_q) else $error("pending not dropped"); // R10
endmodule

// File: rtl/pwm_wave_gen.sv
// Period counter and waveform compare. Counts ticks 0..P-1 (P=0 acts as 1),
// flags the first cycle of each new period, and reports active level.
module pwm_wave_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         chan_en,
    input  logic         tick,
    input  logic [W-1:0] period_q,
    input  logic [W-1:0] duty_q,
    output logic         boundary,
    output logic         start_q,
    output logic         active,
    output logic [W-1:0] cnt_q
);
    logic [W:0] cnt_nxt;

    // Wrap detection and inactive/active compare.
    always_comb begin
        cnt_nxt  = {1'b0, cnt_q} + (W+1)'(1);
        boundary = tick && (cnt_nxt >= {1'b0, period_q});
        active   = (cnt_q >= duty_q);
    end

    // Step the counter and register the period-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) begin
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            if (boundary)  cnt_q <= '0;
            else if (tick) cnt_q <= cnt_nxt[W-1:0];
            start_q <= boundary;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && !tick |=> $stable(cnt_q)) else $error("count moved without tick"); // R1
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> cnt_q == '0 && !start_q) else $error("idle not cleared"); // R10
endmodule

// File: rtl/pwm_dbuf_channel.sv
// Top of one double-buffered PWM channel: prescaler, live/buffer registers
// and waveform generator. The output is the inactive level whenever stopped.
module pwm_dbuf_channel
    import pwm_chan_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [PRES_W-1:0] pres_sel,
    input  logic              pol_inv,
    input  logic              dir_wr,
    input  logic [W-1:0]      dir_period,
    input  logic [W-1:0]      dir_duty,
    input  logic              upd_wr,
    input  logic              upd_sel,
    input  logic [W-1:0]      upd_val,
    output logic              pwm_out,
    output logic              period_start
);
    logic         tick, boundary, active;
    logic [W-1:0] period_q, duty_q, cnt_q;

    pwm_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pres_sel(pres_sel), .tick(tick)
    );

    pwm_live_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .boundary(boundary),
        .dir_wr(dir_wr), .dir_period(dir_period), .dir_duty(dir_duty),
        .upd_wr(upd_wr), .upd_sel(upd_sel), .upd_val(upd_val),
        .period_q(period_q), .duty_q(duty_q)
    );

    pwm_wave_gen #(.W(W)) u_wave (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick(tick),
        .period_q(period_q), .duty_q(duty_q), .boundary(boundary),
        .start_q(period_start), .active(active), .cnt_q(cnt_q)
    );

    // Apply polarity; stopped channel sits at the inactive level.
    always_comb pwm_out = (chan_en && active) ^ pol_inv;

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> cnt_q == '0) else $error("start not at count 0"); // R2
endmodule

// File: tb/sim_pwm_dbuf_channel.sv
module sim_pwm_dbuf_channel;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 0, rst_n = 0, chan_en = 0, pol_inv = 0;
    logic [3:0] pres_sel = 0;
    logic dir_wr = 0, upd_wr = 0, upd_sel = 0;
    logic [W-1:0] dir_period = 0, dir_duty = 0, upd_val = 0;
    logic pwm_out, period_start;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    pwm_dbuf_channel #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pres_sel(pres_sel),
        .pol_inv(pol_inv), .dir_wr(dir_wr), .dir_period(dir_period),
        .dir_duty(dir_duty), .upd_wr(upd_wr), .upd_sel(upd_sel),
        .upd_val(upd_val), .pwm_out(pwm_out), .period_start(period_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int shift_of(input int p);
        return (p > 10) ? 10 : p;
    endfunction

    function automatic bit exp_out(input int i, input int d, input int sh, input bit pol);
        return (((i >> sh) >= d) ? 1'b1 : 1'b0) ^ pol;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to a negedge where period_start is high.
    task automatic wait_start(input string req);
        int k;
        k = 0;
        @(negedge clk);
        while (!period_start && k < 5000) begin
            @(negedge clk);
            k++;
        end
        check(period_start, req, period_start, 1);
    endtask

    // Check one full period from its first cycle; optional write at index wr_at
    // (kind 1: update port, kind 2: direct write of val to both values).
    task automatic check_period(input int p, input int d, input int sh, input bit pol,
                                input int wr_at, input int kind, input bit sel,
                                input int val, input string req);
        int len, bad_i, bad_v;
        len = p << sh;
        bad_i = -1;
        bad_v = 0;
        for (int i = 0; i < len; i++) begin
            if (pwm_out !== exp_out(i, d, sh, pol) && bad_i < 0) begin
                bad_i = i;
                bad_v = pwm_out;
            end
            if (i > 0 && period_start && bad_i < 0) begin
                bad_i = i;
                bad_v = 2;
            end
            if (i == wr_at && kind == 1) begin
                upd_wr = 1; upd_sel = sel; upd_val = W'(val);
            end
            if (i == wr_at && kind == 2) begin
                dir_wr = 1; dir_period = W'(val); dir_duty = W'(val);
            end
            @(negedge clk);
            upd_wr = 0;
            dir_wr = 0;
        end
        check(bad_i < 0, {req, " waveform (bad index)"}, bad_i, -1);
        check(period_start === 1'b1, {req, " next period_start"}, period_start, 1);
        if (bad_i >= 0) $display("  detail: value %0d", bad_v);
    endtask

    task automatic setup(input int p, input int d, input int pr, input bit pol);
        chan_en = 0;
        @(negedge clk);
        pres_sel = 4'(pr); pol_inv = pol;
        dir_wr = 1; dir_period = W'(p); dir_duty = W'(d);
        @(negedge clk);
        dir_wr = 0;
        chan_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check(pwm_out === 1'b0, "R11 reset output", pwm_out, 0);
        check(period_start === 1'b0, "R11 reset period_start", period_start, 0);
        rst_n = 1;
        @(negedge clk);

        // R10: stopped channel holds inactive level, no pulses.
        pol_inv = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out !== 1'b1 || period_start !== 1'b0) begin
                check(0, "R10 idle level", pwm_out, 1);
                break;
            end
        end
        check(pwm_out === 1'b1, "R10 idle level pol=1", pwm_out, 1);

        // R3/R2 basic, both polarities.
        setup(6, 2, 0, 0); wait_start("R2 first start");
        check_period(6, 2, 0, 0, -1, 0, 0, 0, "R3 p6 d2 pol0");
        setup(6, 2, 1, 1); wait_start("R2 first start");
        check_period(6, 2, 1, 1, -1, 0, 0, 0, "R3 p6 d2 pol1");

        // R4 extremes.
        setup(5, 0, 1, 0); wait_start("R4 start");
        check_period(5, 0, 1, 0, -1, 0, 0, 0, "R4 duty 0 all active");
        setup(5, 5, 1, 0); wait_start("R4 start");
        check_period(5, 5, 1, 0, -1, 0, 0, 0, "R4 duty=P all inactive");

        // R1 prescale 10 and clamp of 15.
        setup(2, 1, 10, 0); wait_start("R1 start");
        check_period(2, 1, 10, 0, -1, 0, 0, 0, "R1 pres 10");
        setup(2, 1, 15, 0); wait_start("R1 start");
        check_period(2, 1, 15 > 10 ? 10 : 15, 0, -1, 0, 0, 0, "R1 pres 15 clamps");

        // R5/R6: buffered period update, then buffered duty update.
        setup(8, 3, 1, 0); wait_start("R5 start");
        check_period(8, 3, 1, 0, 2, 1, 1, 4, "R5 R6 period held this period");
        check_period(4, 3, 1, 0, 1, 1, 0, 1, "R6 period live, duty held");
        check_period(4, 1, 1, 0, -1, 0, 0, 0, "R5 R6 duty live");

        // R7: write in last cycle of the period waits one more period.
        setup(6, 2, 1, 0); wait_start("R7 start");
        check_period(6, 2, 1, 0, 11, 1, 0, 5, "R7 boundary write");
        check_period(6, 2, 1, 0, -1, 0, 0, 0, "R7 still old next period");
        check_period(6, 5, 1, 0, -1, 0, 0, 0, "R7 applied one period later");

        // R9: direct write ignored while enabled.
        setup(6, 2, 0, 0); wait_start("R9 start");
        check_period(6, 2, 0, 0, 1, 2, 0, 3, "R9 direct write while running");
        check_period(6, 2, 0, 0, -1, 0, 0, 0, "R9 unchanged after direct write");

        // R10: held update discarded when stopped.
        setup(6, 2, 0, 0); wait_start("R10 start");
        upd_wr = 1; upd_sel = 0; upd_val = 4;
        @(negedge clk);
        upd_wr = 0; chan_en = 0;
        @(negedge clk);
        chan_en = 1;
        wait_start("R10 restart");
        check_period(6, 2, 0, 0, -1, 0, 0, 0, "R10 pending dropped");

        // R8: update port while stopped loads at once.
        chan_en = 0;
        @(negedge clk);
        upd_wr = 1; upd_sel = 1; upd_val = 9;
        @(negedge clk);
        upd_wr = 0; chan_en = 1;
        wait_start("R8 start");
        check_period(9, 2, 0, 0, -1, 0, 0, 0, "R8 stopped update immediate");

        // Random mix.
        for (int it = 0; it < 12; it++) begin
            int p, d, pr, sh, d2, at;
            bit pol;
            p = 1 + int'($urandom_range(19));
            d = int'($urandom_range(p));
            pr = int'($urandom_range(3));
            pol = 1'($urandom_range(1));
            sh = shift_of(pr);
            d2 = int'($urandom_range(p + 1));
            at = int'($urandom_range((p << sh) - 1));
            setup(p, d, pr, pol); wait_start("R2 random start");
            check_period(p, d, sh, pol, -1, 0, 0, 0, "R3 random");
            check_period(p, d, sh, pol, at, 1, 0, d2, "R5 random held");
            if (at == (p << sh) - 1) begin
                check_period(p, d, sh, pol, -1, 0, 0, 0, "R7 random boundary");
            end
            check_period(p, d2, sh, pol, -1, 0, 0, 0, "R5 random applied");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule